// File: doc/BRIEF.md
# Stereo Second-Order Delta-Sigma Bitstream Modulator

This block converts two channels of oversampled, signed 16-bit PCM into two single-bit pulse-density streams. Each channel keeps its most recent sample in a hold register. A new value is captured whenever that channel's valid strobe is high, and it stays in place until the next strobe. On every cycle where the modulator enable `tick` is high, both channels run one step of a second-order noise-shaping loop together, and each emits one output bit. The low-passed mean of a bitstream follows the input level.

The loop uses two delaying integrators. The first integrator accumulates the input minus the feedback. The second accumulates the first integrator's previous value minus twice the feedback. The output bit is the sign of the second integrator. This gives an output equal to the input delayed by two ticks, plus quantisation error shaped by (1 − z⁻¹)². A limiter clamps both integrators so the loop cannot wrap, even at full-scale input.

In a typical system, `tick` is high on every second master clock. A master clock of 384 times the audio rate then gives a modulator rate of 192 times the audio rate.

Top module: `sdm2_stereo`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears both integrators and both sample holds, and drives `l_bit` and `r_bit` to 0.
- R2: Outputs and integrators change only on an edge where `tick` is high. Each such edge produces exactly one new bit per channel, and both channels update on that same edge.
- R3: Both integrators of each channel saturate at ±(2^19 − 1) and never leave that range. The integrators are 20 bits, which is 4 bits wider than the input.
- R4: The quantiser decision is the sign of the second integrator, with zero treated as positive. A decision of positive gives output bit 1. The first tick after reset therefore yields bit 1 on both channels.
- R5: The feedback value is +32768 when the decision is 1 and −32768 when it is 0. Per tick, with x the held sample and y the feedback, the updates are: i1 ← sat(i1 + x − y) and i2 ← sat(i2 + i1_old − 2y).
- R6: Each channel's hold register loads its input only when its own valid strobe is high (zero-order hold). When a strobe and `tick` occur on the same edge, that tick uses the previously held value.
- R7: The two channels are independent. Different inputs on left and right give bitstreams that each match their own channel's loop.
- R8: For a constant input x, the bitstream mean (2·ones − N)·32768/N over N = 2048 ticks lies within 256 of x. This holds for inputs well inside full scale.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Modulator clock enable, one step per high cycle |
| l_in | input | 16 | Left sample, signed two's complement |
| l_vld | input | 1 | Left sample strobe |
| r_in | input | 16 | Right sample, signed two's complement |
| r_vld | input | 1 | Right sample strobe |
| l_bit | output | 1 | Left bitstream |
| r_bit | output | 1 | Right bitstream |

## Verification
A zero input is expected to give a near-alternating stream. Mid-scale positive and negative DC levels separate correct feedback polarity and magnitude from a sign error through the bitstream mean. Different levels on left and right expose any cross-coupling between the channels. Sustained positive and negative full-scale inputs push the integrators into the limiter, so a design that wraps or clamps at the wrong value departs from the tick-by-tick reference stream. One test lands a sample strobe on the same edge as a tick, which checks the zero-order hold ordering. Idle gaps with `tick` low check that nothing advances between enables.

// File: rtl/sdm2_stereo.sv
module sdm2_stereo #(
  parameter int IN_W  = 16,
  parameter int GUARD = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic [IN_W-1:0] l_in,
  input  logic            l_vld,
  input  logic [IN_W-1:0] r_in,
  input  logic            r_vld,
  output logic            l_bit,
  output logic            r_bit
);
  localparam int ACC_W = IN_W + GUARD;
  localparam int SUM_W = ACC_W + 2;
  localparam logic signed [SUM_W-1:0] FS   = SUM_W'(2 ** (IN_W - 1));
  localparam logic signed [SUM_W-1:0] LIM  = SUM_W'(2 ** (ACC_W - 1) - 1);
  localparam logic signed [SUM_W-1:0] NLIM = -LIM;

  function automatic logic signed [SUM_W-1:0] ext_in(input logic [IN_W-1:0] v);
    return $signed({{(SUM_W-IN_W){v[IN_W-1]}}, v});
  endfunction

  function automatic logic signed [SUM_W-1:0] ext_acc(input logic [ACC_W-1:0] v);
    return $signed({{(SUM_W-ACC_W){v[ACC_W-1]}}, v});
  endfunction

  function automatic logic [ACC_W-1:0] clamp(input logic signed [SUM_W-1:0] v);
    if (v > LIM)       return LIM[ACC_W-1:0];
    else if (v < NLIM) return NLIM[ACC_W-1:0];
    else               return v[ACC_W-1:0];
  endfunction

  logic [1:0][IN_W-1:0]  din;
  logic [1:0]            dvld;
  logic [1:0][IN_W-1:0]  hold_all;
  logic [1:0][ACC_W-1:0] i1_all;
  logic [1:0][ACC_W-1:0] i2_all;
  logic [1:0]            q_all;

  assign din  = {r_in, l_in};
  assign dvld = {r_vld, l_vld};

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    logic [IN_W-1:0]         hold;
    logic [ACC_W-1:0]        i1, i2;
    logic                    q;
    logic                    dec;
    logic signed [SUM_W-1:0] fb, s1, s2;

    assign dec = ~i2[ACC_W-1];
    assign fb  = dec ? FS : -FS;
    assign s1  = ext_acc(i1) + ext_in(hold) - fb;
    assign s2  = ext_acc(i2) + ext_acc(i1) - fb - fb;

    always_ff @(posedge clk) begin
      if (rst) begin
        hold <= '0;
        i1   <= '0;
        i2   <= '0;
        q    <= 1'b0;
      end else begin
        if (dvld[ch]) hold <= din[ch];
        if (tick) begin
          i1 <= clamp(s1);
          i2 <= clamp(s2);
          q  <= dec;
        end
      end
    end

    assign hold_all[ch] = hold;
    assign i1_all[ch]   = i1;
    assign i2_all[ch]   = i2;
    assign q_all[ch]    = q;
  end

  assign l_bit = q_all[0];
  assign r_bit = q_all[1];
endmodule

// File: rtl/sdm2_stereo_chk.sv
module sdm2_stereo_chk #(
  parameter int IN_W  = 16,
  parameter int ACC_W = 20
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  tick,
  input logic                  l_vld,
  input logic                  r_vld,
  input logic                  l_bit,
  input logic                  r_bit,
  input logic [1:0][IN_W-1:0]  hold_all,
  input logic [1:0][ACC_W-1:0] i1_all,
  input logic [1:0][ACC_W-1:0] i2_all
);
  localparam logic signed [ACC_W-1:0] LIM = ACC_W'(2 ** (ACC_W - 1) - 1);

  logic [1:0] bits;
  logic [1:0] vlds;
  assign bits = {r_bit, l_bit};
  assign vlds = {r_vld, l_vld};

  p_clear_r1: assert property (@(posedge clk)
    rst |=> (bits == 2'b00 && i1_all == '0 && i2_all == '0 && hold_all == '0));

  p_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(bits) && $stable(i1_all) && $stable(i2_all)));

  for (genvar ch = 0; ch < 2; ch++) begin : g_chk
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
      ($signed(i1_all[ch]) >= -LIM && $signed(i2_all[ch]) >= -LIM));

    p_sign_r4: assert property (@(posedge clk) disable iff (rst)
      tick |=> (bits[ch] == ~$past(i2_all[ch][ACC_W-1])));

    p_zoh_r6: assert property (@(posedge clk) disable iff (rst)
      !vlds[ch] |=> $stable(hold_all[ch]));
  end
endmodule

bind sdm2_stereo sdm2_stereo_chk #(.IN_W(IN_W), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .l_vld(l_vld), .r_vld(r_vld),
  .l_bit(l_bit), .r_bit(r_bit), .hold_all(hold_all),
  .i1_all(i1_all), .i2_all(i2_all)
);

// File: tb/sdm2_stereo_tb.sv
module sdm2_stereo_tb;
  localparam int  CLK_PERIOD = 10;
  localparam longint FS  = 32768;
  localparam longint LIM = 524287;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0;
  logic [15:0] l_in = '0, r_in = '0;
  logic l_vld = 1'b0, r_vld = 1'b0;
  logic l_bit, r_bit;

  int total = 0, bad = 0;
  int ones_l = 0, ones_r = 0, nticks = 0;
  bit finished = 0;
  logic [1:0] expq[$];

  longint m_h[2], m_1[2], m_2[2];

  always #(CLK_PERIOD/2) clk = ~clk;

  sdm2_stereo u_dut (
    .clk(clk), .rst(rst), .tick(tick),
    .l_in(l_in), .l_vld(l_vld), .r_in(r_in), .r_vld(r_vld),
    .l_bit(l_bit), .r_bit(r_bit)
  );

  function automatic longint sat(input longint v);
    if (v > LIM) return LIM;
    if (v < -LIM) return -LIM;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference step, R4/R5
  function automatic logic [1:0] model_step();
    logic [1:0] q;
    for (int ch = 0; ch < 2; ch++) begin
      longint y, n1, n2;
      q[ch] = (m_2[ch] >= 0);
      y  = q[ch] ? FS : -FS;
      n1 = sat(m_1[ch] + m_h[ch] - y);
      n2 = sat(m_2[ch] + m_1[ch] - 2 * y);
      m_1[ch] = n1;
      m_2[ch] = n2;
    end
    return q;
  endfunction

  task automatic do_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      expq.push_back(model_step());
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic set_samples(input int lv, input int rv, input bit dol, input bit dor);
    @(negedge clk);
    l_in = 16'(lv); r_in = 16'(rv); l_vld = dol; r_vld = dor;
    if (dol) m_h[0] = longint'($signed(16'(lv)));
    if (dor) m_h[1] = longint'($signed(16'(rv)));
    @(negedge clk);
    l_vld = 1'b0; r_vld = 1'b0;
  endtask

  task automatic clear_stats();
    ones_l = 0; ones_r = 0; nticks = 0;
  endtask

  task automatic check_mean(input int lv, input int rv);
    longint ml, mr;
    ml = (2 * longint'(ones_l) - nticks) * FS / nticks;
    mr = (2 * longint'(ones_r) - nticks) * FS / nticks;
    check((ml - lv <= 256) && (lv - ml <= 256), "R8 left mean", ml, lv);
    check((mr - rv <= 256) && (rv - mr <= 256), "R8 right mean", mr, rv);
  endtask

  task automatic dc_run(input int lv, input int rv);
    set_samples(lv, rv, 1'b1, 1'b1);
    do_ticks(256);
    clear_stats();
    do_ticks(2048);
    check_mean(lv, rv);
  endtask

  // monitor / scoreboard, R2/R7
  initial begin
    forever begin
      logic t, r;
      @(posedge clk);
      t = tick; r = rst;
      @(negedge clk);
      if (t && !r) begin
        logic [1:0] e;
        if (expq.size() == 0) begin
          check(1'b0, "R2 unexpected tick", 0, 1);
        end else begin
          e = expq.pop_front();
          check({r_bit, l_bit} == e, "R2 R7 bit pair", {r_bit, l_bit}, e);
          nticks++;
          ones_l += int'(l_bit);
          ones_r += int'(r_bit);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic pl, pr;
    for (int ch = 0; ch < 2; ch++) begin m_h[ch] = 0; m_1[ch] = 0; m_2[ch] = 0; end
    repeat (3) @(negedge clk);
    check(l_bit == 1'b0 && r_bit == 1'b0, "R1 reset bits", {r_bit, l_bit}, 0);
    rst = 1'b0;

    // R4: first tick after reset gives 1 on both channels
    do_ticks(1);
    @(negedge clk);
    check(l_bit && r_bit, "R4 first decision", {r_bit, l_bit}, 3);

    // R2: idle without tick, outputs hold
    pl = l_bit; pr = r_bit;
    repeat (6) @(negedge clk);
    check(l_bit == pl && r_bit == pr, "R2 idle hold", {r_bit, l_bit}, {pr, pl});

    // R8 zero input, mid-scale levels, R7 different channels
    dc_run(0, 0);
    dc_run(16384, -16384);
    dc_run(-8192, 24000);

    // R6: strobe on one channel only, other keeps its value
    set_samples(12000, 30000, 1'b1, 1'b0);
    do_ticks(256);
    clear_stats();
    do_ticks(2048);
    check_mean(12000, 24000);

    // R6: strobe coincident with tick uses old hold
    expq.push_back(model_step());
    @(negedge clk);
    l_in = 16'(-20000); l_vld = 1'b1; tick = 1'b1;
    m_h[0] = -20000;
    @(negedge clk);
    l_vld = 1'b0; tick = 1'b0;
    do_ticks(64);

    // R3: full-scale stress drives the limiter
    set_samples(32767, -32768, 1'b1, 1'b1);
    do_ticks(3000);
    set_samples(-32768, 32767, 1'b1, 1'b1);
    do_ticks(3000);

    // R5: recovery after saturation follows the reference
    dc_run(4000, -4000);

    // R1: reset mid-run clears state
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    check(l_bit == 1'b0 && r_bit == 1'b0, "R1 mid reset", {r_bit, l_bit}, 0);
    for (int ch = 0; ch < 2; ch++) begin m_h[ch] = 0; m_1[ch] = 0; m_2[ch] = 0; end
    do_ticks(32);

    repeat (4) @(negedge clk);
    check(expq.size() == 0, "R2 pending items", expq.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule